// File: doc/BRIEF.md
# Serial EEPROM Target Model

This block is a synthesizable SPI target that behaves like a small serial EEPROM. Its storage is an on-chip byte array, so an SPI controller can be brought up and regression-tested against it without an external part. The block samples the SPI pins with its own system clock. It decodes a byte-wide opcode, collects a big-endian address of a configurable number of bytes, and then streams data in or out for as long as chip select stays low.

A status byte exposes a write-in-progress flag, a write-enable latch and three protection bits that are stored but not enforced. A write needs the latch to be set beforehand. Bursts wrap inside their page. Once chip select rises after a write, the block reports busy for a parameter number of clocks. While busy it answers only status reads, and it drops the latch when the busy period ends.

Top module: `spi_ee_model`

## Requirements
- R1: After reset, miso is low and a status read returns 0x00.
- R2: Opcode 0x05 returns the status byte with bit 0 = busy, bit 1 = write-enable latch, bits 3:2 = protect bits, bit 7 = protect enable, and bits 6:4 = 0. The byte is re-sampled and repeated for every further byte while chip select stays low.
- R3: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it, each taking effect when the opcode byte completes.
- R4: Opcode 0x02 followed by ADDR_BYTES address bytes (most significant first) stores each following data byte. When the latch is clear, the whole command is ignored and the array is unchanged.
- R5: Consecutive bytes of a write burst go to consecutive addresses within one PAGE_BYTES-aligned page, wrapping from the page's last byte to its first.
- R6: Opcode 0x03 plus the address streams bytes from consecutive addresses, wrapping at the end of the array. Address bits above the array size are ignored.
- R7: When chip select rises after an accepted write with at least one data byte, or after an accepted status write, busy is set for BUSY_CYCLES clocks. An accepted write with no data byte starts no busy period.
- R8: The write-enable latch clears when a busy period ends.
- R9: While busy, every opcode except 0x05 is ignored, including 0x06, 0x02 and 0x03, and miso returns 0x00 for the remainder of the frame. Unrecognised opcodes are ignored at any time.
- R10: Opcode 0x01 with the latch set stores data bits 7, 3 and 2 into the status byte and leaves the other bits alone. Without the latch it is ignored.
- R11: SPI mode 0, most significant bit first. miso changes after sclk rises, is valid before the next rising edge, and is low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock from the controller |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the controller |
| miso | output | 1 | Serial data to the controller |

## Verification
The SPI pins reach the logic through a two-stage synchronizer, so every serial event takes effect two to three clocks after the pin edge. The bench holds each sclk phase for four clocks and samples miso on the clock just before it raises sclk, which is always at least four clocks after the block updates its shift register. The status byte is captured on the last rising edge of the opcode byte, so the busy window is checked by starting status reads at chosen clock offsets from the chip-select rise. These offsets are computed so that the capture falls clearly inside the busy window or clearly after it. Memory and status contents are compared with a bench model that is updated only for commands the requirements accept.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [2:0] {
    PH_CMD, PH_ADDR, PH_RDATA, PH_WDATA, PH_RSTAT, PH_WSTAT, PH_SKIP
  } phase_t;
endpackage

// File: rtl/spi_ee_front.sv
module spi_ee_front (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic cs_fall,
  output logic cs_rise,
  output logic cs_act,
  output logic mosi_s
);
  logic [2:0] sclk_q;
  logic [2:0] cs_q;
  logic [1:0] mosi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      cs_q   <= {cs_q[1:0], cs_n};
      mosi_q <= {mosi_q[0], mosi};
    end
  end

  assign sclk_rise = sclk_q[1] & ~sclk_q[2];
  assign cs_act    = ~cs_q[1];
  assign cs_fall   = ~cs_q[1] & cs_q[2];
  assign cs_rise   = cs_q[1] & ~cs_q[2];
  assign mosi_s    = mosi_q[1];
endmodule

// File: rtl/spi_ee_timer.sv
module spi_ee_timer #(
  parameter int unsigned CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)
      cnt_d = CW'(CYCLES);
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CW'(1)) & ~start;
endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
  parameter int DEPTH = 256,
  parameter int IW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [IW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/spi_ee_model.sv
module spi_ee_model #(
  parameter int ADDR_BYTES  = 2,
  parameter int MEM_BYTES   = 256,
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic miso
);
  import spi_ee_pkg::*;

  localparam int AW = 8 * ADDR_BYTES;
  localparam int IW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);

  logic [1:0] rst_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_ns = rst_q[1];

  logic sclk_rise, cs_fall, cs_rise, cs_act, mosi_s;

  spi_ee_front u_front (
    .clk(clk), .rst_n(rst_ns), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .sclk_rise(sclk_rise), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .cs_act(cs_act), .mosi_s(mosi_s)
  );

  logic busy, done, start;

  spi_ee_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_ns), .start(start), .busy(busy), .done(done)
  );

  phase_t         phase_q, phase_d;
  logic [2:0]     bitc_q, bitc_d;
  logic [6:0]     rx_q, rx_d;
  logic [7:0]     tx_q, tx_d;
  logic [AW-1:0]  addr_q, addr_d;
  logic [1:0]     acnt_q, acnt_d;
  logic           wr_q, wr_d;
  logic           wel_q, wel_d;
  logic [1:0]     bp_q, bp_d;
  logic           wpen_q, wpen_d;
  logic           pend_q, pend_d;

  logic           bit_ev, byte_done;
  logic [7:0]     rx_byte, stat, tx_nxt, mem_rd;
  logic [AW-1:0]  addr_new;
  logic           mem_we;
  logic [IW-1:0]  mem_ra;
  logic           in_wdata;

  assign bit_ev    = sclk_rise & cs_act;
  assign byte_done = bit_ev & (bitc_q == 3'd7);
  assign rx_byte   = {rx_q, mosi_s};
  assign stat      = {wpen_q, 3'b000, bp_q, wel_q, busy};
  assign addr_new  = AW'({addr_q, rx_byte});
  assign start     = cs_rise & pend_q;
  assign in_wdata  = (phase_q == PH_WDATA);

  spi_ee_array #(.DEPTH(MEM_BYTES), .IW(IW)) u_array (
    .clk(clk), .we(mem_we), .waddr(addr_q[IW-1:0]), .wdata(rx_byte),
    .raddr(mem_ra), .rdata(mem_rd)
  );

  always_comb begin
    phase_d = phase_q;
    bitc_d  = bitc_q;
    rx_d    = rx_q;
    tx_d    = tx_q;
    addr_d  = addr_q;
    acnt_d  = acnt_q;
    wr_d    = wr_q;
    wel_d   = wel_q;
    bp_d    = bp_q;
    wpen_d  = wpen_q;
    pend_d  = pend_q;
    tx_nxt  = 8'h00;
    mem_we  = 1'b0;
    mem_ra  = addr_q[IW-1:0];

    if (done) wel_d = 1'b0;
    if (cs_rise) pend_d = 1'b0;

    if (cs_fall) begin
      phase_d = PH_CMD;
      bitc_d  = '0;
      tx_d    = '0;
    end else if (bit_ev) begin
      bitc_d = bitc_q + 1'b1;
      rx_d   = rx_byte[6:0];
      if (byte_done) begin
        unique case (phase_q)
          PH_CMD: begin
            phase_d = PH_SKIP;
            acnt_d  = '0;
            if (!busy || rx_byte == OP_RDSR) begin
              unique case (rx_byte)
                OP_WREN:  wel_d = 1'b1;
                OP_WRDI:  wel_d = 1'b0;
                OP_RDSR:  begin phase_d = PH_RSTAT; tx_nxt = stat; end
                OP_WRSR:  if (wel_q) phase_d = PH_WSTAT;
                OP_READ:  begin phase_d = PH_ADDR; wr_d = 1'b0; end
                OP_WRITE: if (wel_q) begin phase_d = PH_ADDR; wr_d = 1'b1; end
                default:  phase_d = PH_SKIP;
              endcase
            end
          end
          PH_ADDR: begin
            addr_d = addr_new;
            acnt_d = acnt_q + 1'b1;
            if (acnt_q == 2'(ADDR_BYTES - 1)) begin
              if (wr_q) begin
                phase_d = PH_WDATA;
              end else begin
                phase_d = PH_RDATA;
                mem_ra  = addr_new[IW-1:0];
                tx_nxt  = mem_rd;
                addr_d  = addr_new + 1'b1;
              end
            end
          end
          PH_RDATA: begin
            tx_nxt = mem_rd;
            addr_d = addr_q + 1'b1;
          end
          PH_WDATA: begin
            mem_we = 1'b1;
            pend_d = 1'b1;
            addr_d = {addr_q[AW-1:PW], PW'(addr_q[PW-1:0] + 1'b1)};
          end
          PH_RSTAT: tx_nxt = stat;
          PH_WSTAT: begin
            wpen_d  = rx_byte[7];
            bp_d    = rx_byte[3:2];
            pend_d  = 1'b1;
            phase_d = PH_SKIP;
          end
          default: phase_d = PH_SKIP;
        endcase
        tx_d = tx_nxt;
      end else begin
        tx_d = {tx_q[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      phase_q <= PH_CMD;
      bitc_q  <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      addr_q  <= '0;
      acnt_q  <= '0;
      wr_q    <= 1'b0;
      wel_q   <= 1'b0;
      bp_q    <= '0;
      wpen_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      bitc_q  <= bitc_d;
      rx_q    <= rx_d;
      tx_q    <= tx_d;
      addr_q  <= addr_d;
      acnt_q  <= acnt_d;
      wr_q    <= wr_d;
      wel_q   <= wel_d;
      bp_q    <= bp_d;
      wpen_q  <= wpen_d;
      pend_q  <= pend_d;
    end
  end

  assign miso = cs_act & tx_q[7];
endmodule

// File: rtl/spi_ee_checker.sv
module spi_ee_checker #(
  parameter int BUSY_CYCLES = 200,
  parameter int HW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_rise,
  input logic          busy,
  input logic          wel,
  input logic          mem_we,
  input logic          in_wdata,
  input logic [HW-1:0] page_bits
);
  int unsigned run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= 0;
    else if (busy) run_q <= run_q + 1;
    else           run_q <= 0;
  end

  AST_BUSY_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise)); // R7
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == BUSY_CYCLES)); // R7
  AST_WEL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel); // R8
  AST_WE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (wel && !busy)); // R4
  AST_WEL_IDLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> !busy); // R9
  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wdata && $past(in_wdata)) |-> $stable(page_bits)); // R5
endmodule

bind spi_ee_model spi_ee_checker #(
  .BUSY_CYCLES(BUSY_CYCLES),
  .HW(8 * ADDR_BYTES - $clog2(PAGE_BYTES))
) u_chk (
  .clk(clk),
  .rst_n(rst_ns),
  .cs_rise(cs_rise),
  .busy(busy),
  .wel(wel_q),
  .mem_we(mem_we),
  .in_wdata(in_wdata),
  .page_bits(addr_q[8*ADDR_BYTES-1:$clog2(PAGE_BYTES)])
);

// File: tb/tb_spi_ee_model.sv
module tb_spi_ee_model;
  localparam int MB = 256;
  localparam int PB = 16;
  localparam int BC = 1200;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  int unsigned cyc = 0, t_rise = 0;
  int n_tests = 0, n_fail = 0;

  logic [7:0] ref_mem [MB];
  logic [7:0] wbuf [32];
  logic [7:0] rbuf [260];
  logic       m_wel = 1'b0, m_wpen = 1'b0;
  logic [1:0] m_bp = 2'b00;

  spi_ee_model #(.ADDR_BYTES(2), .MEM_BYTES(MB), .PAGE_BYTES(PB), .BUSY_CYCLES(BC)) dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] exp_stat(input logic b);
    return {m_wpen, 3'b000, m_bp, m_wel, b};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_lo();
    cs_n = 1'b0; half(); half();
  endtask

  task automatic cs_hi();
    half(); cs_n = 1'b1; t_rise = cyc; repeat (8) @(negedge clk);
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i]; half();
      rx[i] = miso; sclk = 1'b1; half();
      sclk = 1'b0;
    end
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    cs_lo(); spi_byte(op, r); cs_hi();
  endtask

  task automatic rd_status(output logic [7:0] s);
    logic [7:0] r;
    cs_lo(); spi_byte(8'h05, r); spi_byte(8'h00, s); cs_hi();
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int k = 0; k < 100; k++) begin
      rd_status(s);
      if (!s[0]) break;
    end
  endtask

  task automatic do_read(input logic [15:0] a, input int n);
    logic [7:0] r;
    cs_lo(); spi_byte(8'h03, r); spi_byte(a[15:8], r); spi_byte(a[7:0], r);
    for (int i = 0; i < n; i++) spi_byte(8'h00, rbuf[i]);
    cs_hi();
  endtask

  task automatic do_write(input logic [15:0] a, input int n, input bit wait_end);
    logic [7:0] r;
    int base;
    cs_lo(); spi_byte(8'h02, r); spi_byte(a[15:8], r); spi_byte(a[7:0], r);
    for (int i = 0; i < n; i++) spi_byte(wbuf[i], r);
    cs_hi();
    base = int'(a[7:0]) & ~(PB - 1);
    if (m_wel && n > 0) begin
      for (int i = 0; i < n; i++) ref_mem[base + ((int'(a[7:0]) + i) % PB)] = wbuf[i];
      if (wait_end) begin wait_idle(); m_wel = 1'b0; end
    end
  endtask

  task automatic cmp_read(input string tag, input logic [15:0] a, input int n);
    do_read(a, n);
    for (int i = 0; i < n; i++) chk(tag, rbuf[i], ref_mem[(int'(a[7:0]) + i) % MB]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] s, r;
    int unsigned t0;
    void'($urandom(32'h5EED));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    chk("R11 miso low while deselected", miso, 0);
    rd_status(s); chk("R1 reset status", s, 8'h00);

    cmd1(8'h06); m_wel = 1'b1;
    rd_status(s); chk("R3 enable latch set", s, 8'h02);
    cmd1(8'h04); m_wel = 1'b0;
    rd_status(s); chk("R3 enable latch cleared", s, 8'h00);

    // fill every page
    for (int p = 0; p < MB / PB; p++) begin
      for (int i = 0; i < PB; i++) wbuf[i] = 8'((p * PB + i) ^ 8'h5A);
      cmd1(8'h06); m_wel = 1'b1;
      do_write(16'(p * PB), PB, 1'b1);
    end
    cmp_read("R6 full stream read", 16'h0000, MB);

    // write without latch
    for (int i = 0; i < 4; i++) wbuf[i] = 8'hA0 + 8'(i);
    do_write(16'h0020, 4, 1'b0);
    rd_status(s); chk("R7 no cycle for refused write", s, 8'h00);
    cmp_read("R4 refused write leaves array", 16'h0020, 4);

    // page wrap plus busy window
    for (int i = 0; i < 8; i++) wbuf[i] = 8'hC0 + 8'(i);
    cmd1(8'h06); m_wel = 1'b1;
    do_write(16'h003C, 8, 1'b0);
    t0 = t_rise;
    rd_status(s); chk("R7 busy right after write", s, 8'h03);
    cmd1(8'h06);
    cs_lo(); spi_byte(8'h02, r); spi_byte(8'h00, r); spi_byte(8'h50, r); spi_byte(8'hEE, r); cs_hi();
    do_read(16'h0030, 2);
    chk("R9 read refused while busy", rbuf[0], 8'h00);
    chk("R9 read refused while busy", rbuf[1], 8'h00);
    while (cyc < t0 + 1000) @(negedge clk);
    rd_status(s); chk("R7 still busy late in window", s, 8'h03);
    while (cyc < t0 + 1260) @(negedge clk);
    m_wel = 1'b0;
    rd_status(s); chk("R8 latch dropped at end of busy", s, 8'h00);
    cmp_read("R5 page wrap contents", 16'h0030, 16);
    cmp_read("R9 write refused while busy", 16'h0050, 1);

    // accepted write without data
    cmd1(8'h06); m_wel = 1'b1;
    cs_lo(); spi_byte(8'h02, r); spi_byte(8'h00, r); spi_byte(8'h10, r); cs_hi();
    rd_status(s); chk("R7 no cycle without data", s, 8'h02);
    cmd1(8'h04); m_wel = 1'b0;

    // status writes
    cmd1(8'h06); m_wel = 1'b1;
    cs_lo(); spi_byte(8'h01, r); spi_byte(8'hFF, r); cs_hi();
    m_bp = 2'b11; m_wpen = 1'b1;
    rd_status(s); chk("R10 status write starts cycle", s, 8'h8F);
    wait_idle(); m_wel = 1'b0;
    rd_status(s); chk("R10 writable bits stored", s, 8'h8C);
    cs_lo(); spi_byte(8'h01, r); spi_byte(8'h00, r); cs_hi();
    rd_status(s); chk("R10 status write refused without latch", s, 8'h8C);
    cmd1(8'h06); m_wel = 1'b1;
    cs_lo(); spi_byte(8'h01, r); spi_byte(8'h00, r); cs_hi();
    m_bp = 2'b00; m_wpen = 1'b0;
    wait_idle(); m_wel = 1'b0;
    rd_status(s); chk("R10 status cleared", s, 8'h00);

    // repeated status bytes
    cmd1(8'h06); m_wel = 1'b1;
    cs_lo(); spi_byte(8'h05, r);
    for (int i = 0; i < 3; i++) begin spi_byte(8'h00, s); chk("R2 status repeats", s, exp_stat(1'b0)); end
    cs_hi();
    cmd1(8'h04); m_wel = 1'b0;

    // unknown opcode
    cs_lo(); spi_byte(8'hAB, r); spi_byte(8'h00, s); cs_hi();
    chk("R9 unknown opcode returns zero", s, 8'h00);
    rd_status(s); chk("R9 unknown opcode no state change", s, 8'h00);

    cmp_read("R6 wrap at array end", 16'h00FE, 4);
    cmp_read("R6 upper address bits ignored", 16'h12F0, 2);

    // constrained random writes and reads
    for (int it = 0; it < 8; it++) begin
      logic [15:0] a;
      int n;
      a = 16'($urandom);
      n = 1 + int'($urandom % 20);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      if (($urandom % 4) != 0) begin cmd1(8'h06); m_wel = 1'b1; end
      do_write(a, n, 1'b1);
      rd_status(s); chk("R8 idle after random write", s, 8'h00);
      cmp_read("R5 random write readback", {a[15:8], a[7:0] & 8'hF0}, PB);
      cmp_read("R6 random read", 16'($urandom), 1 + int'($urandom % 24));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule